// File: doc/BRIEF.md
# Multi-lane serial packet framer

This block turns local-bus write requests into framed packets for a serial chip-to-chip link with one to eight transmit lanes. A request arrives as a header beat (command, address mask, 32-bit address, burst length) followed by a burst of one, four or sixteen 32-bit data words on a separate valid/ready channel. Once the whole burst is held, the framer emits the packet as a sequence of 8-bit symbols, each tagged with a control flag, for a downstream 8b/10b encoder.

Each cycle, the framer deals consecutive symbols across the configured lanes in round-robin order. It pads a partly filled last cycle and every unused lane with an idle control symbol. While the receiver throttle input is high, the framer holds its place in the packet and the lanes carry idle symbols.

Top module: `lane_framer`

## Requirements
- R1: While no packet is being collected or sent, including right after reset, every lane carries the idle control symbol 0xBC with its control flag set, `hdr_ready` is 1 and `wd_ready` is 0.
- R2: A header is taken only when `hdr_ready` is 1. From the accepting edge until the edge on which the end-of-packet symbol leaves, `hdr_ready` stays 0. In the cycle after that edge it is 1 again.
- R3: After a header is taken, `wd_ready` is 1 until exactly the number of words set by `hdr_len` has been accepted. `hdr_len` 0 means 1 word, 1 means 4 words, and 2 or 3 mean 16 words. Words offered outside this window have no effect on the output.
- R4: The symbols of a packet go out in this order: start-of-packet (control, 0xFB), command byte, mask byte, byte count, four address bytes (least-significant first), the data bytes, then end-of-packet (control, 0xFD). Only the start, end and idle symbols have the control flag set.
- R5: The byte count symbol equals four times the number of words. Each word is sent as four symbols, least-significant byte first, with words in the order they were accepted.
- R6: With `lane_cfg` = c, c+1 lanes are used. In each sending cycle, lane j carries the next symbol in sequence, offset by j. Lanes at index c+1 and above, and lanes beyond the end of the packet in the last cycle, carry the idle control symbol.
- R7: In a sending cycle where `tx_hold` is 1, every lane carries the idle control symbol and the packet position does not advance. The next cycle with `tx_hold` 0 resumes with the symbols that were held back.
- R8: The first sending cycle follows at once the edge that accepts the last data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_cfg | input | 3 | Active lane count minus one |
| hdr_valid | input | 1 | Header beat offered |
| hdr_ready | output | 1 | Header beat accepted on this edge if valid |
| hdr_cmd | input | 8 | Command / packet type byte |
| hdr_mask | input | 8 | Address mask byte |
| hdr_addr | input | 32 | Target address |
| hdr_len | input | 2 | Burst length code |
| wd_valid | input | 1 | Data word offered |
| wd_ready | output | 1 | Data word accepted on this edge if valid |
| wd_data | input | 32 | Data word |
| tx_hold | input | 1 | Receiver throttle, pauses the symbol stream |
| lane_sym | output | 64 | Symbol byte per lane, lane j at bits 8j+7:8j |
| lane_k | output | 8 | Control-symbol flag per lane |

## Verification
The assertions assume that `lane_cfg` changes only while `hdr_ready` is high, and that the header fields stay steady while `hdr_valid` is high. The stimulus changes the lane count and header fields only in the cycle that offers a new header. It drops `hdr_valid` right after the accepting edge. Data words are offered with random gaps, and junk words are offered while the packet is sending, to show that they are ignored. `tx_hold` is drawn at random on each sending cycle, so pauses fall on header, address, data and end-of-packet positions alike.

// File: rtl/lane_framer.sv
module lane_framer #(
  parameter int LANES    = 8,
  parameter logic [7:0] IDLE_SYM = 8'hBC,
  parameter logic [7:0] SOP_SYM  = 8'hFB,
  parameter logic [7:0] EOP_SYM  = 8'hFD
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           lane_cfg,
  input  logic                 hdr_valid,
  output logic                 hdr_ready,
  input  logic [7:0]           hdr_cmd,
  input  logic [7:0]           hdr_mask,
  input  logic [31:0]          hdr_addr,
  input  logic [1:0]           hdr_len,
  input  logic                 wd_valid,
  output logic                 wd_ready,
  input  logic [31:0]          wd_data,
  input  logic                 tx_hold,
  output logic [8*LANES-1:0]   lane_sym,
  output logic [LANES-1:0]     lane_k
);
  localparam int MAXW = 16;
  localparam int WIX  = $clog2(MAXW);
  localparam int WW   = WIX + 1;
  localparam int LW   = $clog2(LANES) + 1;
  localparam int SIW  = $clog2(9 + 4*MAXW + 2*LANES);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SEND} st_t;
  st_t st;

  logic [7:0]     cmd_q, mask_q;
  logic [31:0]    addr_q;
  logic [WW-1:0]  nw_q, wcnt;
  logic [LW-1:0]  nl_q;
  logic [SIW-1:0] pos, total;
  logic [31:0]    words [MAXW];
  logic           last;

  assign hdr_ready = (st == S_IDLE);
  assign wd_ready  = (st == S_LOAD);
  assign total     = SIW'(9) + SIW'({nw_q, 2'b00});
  assign last      = (pos + SIW'(nl_q)) >= total;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cmd_q  <= '0;
      mask_q <= '0;
      addr_q <= '0;
      nw_q   <= WW'(1);
      nl_q   <= LW'(1);
      wcnt   <= '0;
      pos    <= '0;
    end else begin
      case (st)
        S_IDLE: if (hdr_valid) begin
          cmd_q  <= hdr_cmd;
          mask_q <= hdr_mask;
          addr_q <= hdr_addr;
          nw_q   <= (hdr_len == 2'd0) ? WW'(1) : (hdr_len == 2'd1) ? WW'(4) : WW'(MAXW);
          nl_q   <= LW'(lane_cfg) + LW'(1);
          wcnt   <= '0;
          st     <= S_LOAD;
        end
        S_LOAD: if (wd_valid) begin
          wcnt <= wcnt + WW'(1);
          if (wcnt == nw_q - WW'(1)) begin
            pos <= '0;
            st  <= S_SEND;
          end
        end
        S_SEND: if (!tx_hold) begin
          pos <= pos + SIW'(nl_q);
          if (last) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (st == S_LOAD && wd_valid) words[wcnt[WIX-1:0]] <= wd_data;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [SIW-1:0] idx, d;
    logic [8:0]     s;
    assign idx = pos + SIW'(g);
    assign d   = idx - SIW'(8);
    always_comb begin
      s = {1'b1, IDLE_SYM};
      if (st == S_SEND && !tx_hold && g < int'(nl_q) && idx < total) begin
        if (idx == SIW'(0))              s = {1'b1, SOP_SYM};
        else if (idx == total - SIW'(1)) s = {1'b1, EOP_SYM};
        else if (idx == SIW'(1))         s = {1'b0, cmd_q};
        else if (idx == SIW'(2))         s = {1'b0, mask_q};
        else if (idx == SIW'(3))         s = {1'b0, 8'({nw_q, 2'b00})};
        else if (idx < SIW'(8))          s = {1'b0, addr_q[8*idx[1:0] +: 8]};
        else                             s = {1'b0, words[d[WIX+1:2]][8*d[1:0] +: 8]};
      end
    end
    assign lane_sym[8*g +: 8] = s[7:0];
    assign lane_k[g]          = s[8];

    a_r6_unused_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (g >= int'(nl_q)) |-> (lane_k[g] && lane_sym[8*g +: 8] == IDLE_SYM));
  end

  a_r1_idle_all: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_ready |-> (&lane_k));
  a_r2_ready_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEND && !tx_hold && last) |=> hdr_ready);
  a_r3_word_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_valid && wd_ready) |-> (wcnt < nw_q));
  a_r4_sop_first: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEND && pos == '0 && !tx_hold) |-> (lane_k[0] && lane_sym[7:0] == SOP_SYM));
  a_r7_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEND && tx_hold) |=> (st == S_SEND && $stable(pos)));
endmodule

// File: tb/lane_framer_tb.sv
module lane_framer_tb;
  localparam int PERIOD = 10;
  localparam int L = 8;

  logic clk = 0, rst_n = 0;
  logic [2:0] lane_cfg = 0;
  logic hdr_valid = 0, hdr_ready, wd_valid = 0, wd_ready, tx_hold = 0;
  logic [7:0] hdr_cmd = 0, hdr_mask = 0;
  logic [31:0] hdr_addr = 0, wd_data = 0;
  logic [1:0] hdr_len = 0;
  logic [8*L-1:0] lane_sym;
  logic [L-1:0] lane_k;

  int total_n = 0, bad_n = 0;
  logic [7:0] pc, pm;
  logic [31:0] pa;
  int pn;
  logic [31:0] pw [16];

  always #(PERIOD/2) clk = ~clk;

  lane_framer u_dut (.clk(clk), .rst_n(rst_n), .lane_cfg(lane_cfg),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_cmd(hdr_cmd),
    .hdr_mask(hdr_mask), .hdr_addr(hdr_addr), .hdr_len(hdr_len),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .tx_hold(tx_hold), .lane_sym(lane_sym), .lane_k(lane_k));

  function automatic logic [8:0] esym(int i);
    int tot = 9 + 4*pn;
    if (i == 0) return {1'b1, 8'hFB};
    if (i == tot-1) return {1'b1, 8'hFD};
    if (i == 1) return {1'b0, pc};
    if (i == 2) return {1'b0, pm};
    if (i == 3) return {1'b0, 8'(4*pn)};
    if (i < 8) return {1'b0, pa[8*(i-4) +: 8]};
    return {1'b0, pw[(i-8)/4][8*((i-8)%4) +: 8]};
  endfunction

  function automatic logic all_idle();
    for (int l = 0; l < L; l++)
      if (!(lane_k[l] && lane_sym[8*l +: 8] == 8'hBC)) return 0;
    return 1;
  endfunction

  task automatic chk(logic ok, string req, logic [71:0] act, logic [71:0] exp);
    total_n++;
    if (!ok) begin
      bad_n++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_pkt(logic [2:0] c, logic [1:0] len, int hold_pct);
    int n = c + 1;
    int idx = 0, w = 0, tot;
    pc = 8'($urandom); pm = 8'($urandom); pa = $urandom;
    pn = (len == 0) ? 1 : (len == 1) ? 4 : 16;
    for (int i = 0; i < 16; i++) pw[i] = $urandom;
    tot = 9 + 4*pn;
    @(negedge clk);
    lane_cfg = c; hdr_cmd = pc; hdr_mask = pm; hdr_addr = pa; hdr_len = len; hdr_valid = 1;
    #1;
    chk(hdr_ready && !wd_ready && all_idle(), "R1", {hdr_ready, wd_ready, lane_k}, {1'b1, 1'b0, 8'hFF});
    @(posedge clk); #1 hdr_valid = 0;
    while (w < pn) begin
      @(negedge clk);
      wd_valid = ($urandom % 4) != 0;
      wd_data = pw[w];
      #1;
      chk(wd_ready && !hdr_ready && all_idle(), "R3", {wd_ready, hdr_ready, lane_k}, {1'b1, 1'b0, 8'hFF});
      if (wd_valid) w++;
      @(posedge clk); #1;
    end
    wd_valid = 0;
    while (idx < tot) begin
      @(negedge clk);
      tx_hold = ($urandom % 100) < hold_pct;
      wd_valid = $urandom % 2; wd_data = $urandom;
      #1;
      chk(!hdr_ready && !wd_ready, "R2", {hdr_ready, wd_ready}, 0);
      if (tx_hold) chk(all_idle(), "R7", {lane_k, lane_sym}, {8'hFF, {8{8'hBC}}});
      else begin
        logic ok = 1;
        logic [71:0] ex;
        for (int l = 0; l < L; l++) begin
          logic [8:0] e = (l < n && idx + l < tot) ? esym(idx + l) : {1'b1, 8'hBC};
          ex[8*l +: 8] = e[7:0]; ex[64+l] = e[8];
          if ({lane_k[l], lane_sym[8*l +: 8]} != e) ok = 0;
        end
        chk(ok, (idx == 0) ? "R8 R4" : (idx + n >= tot) ? "R6 R5" : "R4 R5 R6",
            {lane_k, lane_sym}, ex);
        idx += n;
      end
      @(posedge clk); #1;
    end
    tx_hold = 0; wd_valid = 0;
    @(negedge clk); #1;
    chk(hdr_ready && !wd_ready && all_idle(), "R2 R1", {hdr_ready, wd_ready, lane_k}, {1'b1, 1'b0, 8'hFF});
  endtask

  initial begin
    #(PERIOD*200000);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(hdr_ready && !wd_ready && all_idle(), "R1 reset", {hdr_ready, wd_ready, lane_k}, {1'b1, 1'b0, 8'hFF});
    rst_n = 1;
    @(negedge clk); #1;
    chk(hdr_ready && !wd_ready && all_idle(), "R1", {hdr_ready, wd_ready, lane_k}, {1'b1, 1'b0, 8'hFF});
    run_pkt(3'd0, 2'd0, 0);
    run_pkt(3'd7, 2'd2, 0);
    run_pkt(3'd2, 2'd1, 0);
    run_pkt(3'd4, 2'd3, 0);
    run_pkt(3'd0, 2'd2, 50);
    run_pkt(3'd7, 2'd0, 50);
    for (int i = 0; i < 20; i++) run_pkt(3'($urandom), 2'($urandom), 30);
    $display("test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  end
endmodule